// File: doc/BRIEF.md
# Addressed Attenuator Control Front End

This block is the digital control logic for a 7-bit binary-weighted step attenuator. It runs on a fast system clock and oversamples a slow three-wire serial bus (serial clock, serial data, latch strobe), a mode pin and a 7-bit parallel code bus. It drives a registered attenuation code. Bit 0 of the code is the finest step, and each higher bit doubles the weight of the one below it, so bit 6 is the coarsest step.

In serial mode a 16-bit frame is shifted in, least significant bit first. The first byte received is the attenuation word. The second byte carries a device address. When the latch strobe rises, the attenuation word is committed, but only if the low three address bits equal the strapped device address. This lets up to eight devices share one bus. The shift register is frozen while the latch strobe is high.

In parallel mode the code follows the pins while the latch strobe is high. While the strobe is low the code holds, and a rising strobe captures the pins. A one-cycle flag marks every real change of the code.

Top module: `step_atten_ctrl`

## Requirements
- R1: After reset the attenuation code is 7'h7F (all steps in) and the change flag is low.
- R2: In serial mode (`modeSerial` = 1), a 16-bit frame is shifted on each serial clock rise. Frame bit i is the i-th bit sent. Frame bits 7:0 form the attenuation word and bits 15:8 form the address byte. A latch rise commits attenuation bits 6:0 to the code when address bits 10:8 equal `devAddr`. The new code appears on the third system clock edge after the latch pin rises.
- R3: When address bits 10:8 differ from `devAddr`, a latch rise leaves the code unchanged. Address bits 15:11 are don't-care.
- R4: While the latch strobe is high, serial clock edges do not shift the frame register. This includes a serial clock edge that arrives in the same system cycle as the latch rise.
- R5: Frame bit 7 has no effect on the code.
- R6: In parallel mode (`modeSerial` = 0) with the latch high, the code follows `parCode`, with a latency of three system clock edges.
- R7: In parallel mode with the latch low, `parCode` changes are ignored. A latch rise captures `parCode`.
- R8: In serial mode `parCode` has no effect. In parallel mode a serial frame is never committed.
- R9: `codeChanged` is high for exactly the cycles in which the code differs from its value in the previous cycle. Committing an equal value gives no pulse.
- R10: After reset the frame register holds attenuation word 7'h7F with address 000. A latch rise with no serial clocks in between therefore commits 7'h7F when `devAddr` is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial bus clock (asynchronous) |
| serData | input | 1 | Serial bus data (asynchronous) |
| serLatch | input | 1 | Latch strobe, shared by both modes (asynchronous) |
| modeSerial | input | 1 | 1 selects serial control, 0 selects parallel control |
| parCode | input | 7 | Parallel attenuation code |
| devAddr | input | 3 | Strapped device address |
| attenCode | output | 7 | Active attenuation code |
| codeChanged | output | 1 | One-cycle flag on any change of attenCode |

## Verification
A serial clock rise and a latch rise can reach the system clock domain in the same cycle. The bench provokes this by raising both pins on the same system clock edge, after first forcing the code to zero through the parallel path. It then judges the result against the unshifted frame, which commits a known word. A shifted frame would carry a non-matching address and leave the code at zero. A cycle-accurate behavioural model also compares the code and the change flag on every clock, across mode switches and latch edges that land on and off the serial edges.

// File: rtl/atten_ctrl_pkg.sv
package atten_ctrl_pkg;
  localparam int CODE_W = 7;
  localparam int ADDR_W = 3;
  localparam int WORD_W = 8;

  typedef struct packed {
    logic              shiftEn;
    logic              serCommit;
    logic              parLoad;
    logic              dataBit;
    logic [CODE_W-1:0] parValue;
  } ctlStrobe_t;
endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/atten_ctrl_seq.sv
module atten_ctrl_seq
  import atten_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              serLatch,
  input  logic              modeSerial,
  input  logic [CODE_W-1:0] parCode,
  output ctlStrobe_t        strb
);
  localparam int SYNC_W = CODE_W + 4;

  logic [SYNC_W-1:0] syncBus;
  logic              clkS, dataS, leS, modeS;
  logic [CODE_W-1:0] parS;
  logic              clkPrev, lePrev;

  // one synchronizer bank for every asynchronous pin keeps their latencies equal
  atten_sync #(.WIDTH(SYNC_W), .STAGES(2)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({modeSerial, serLatch, serData, serClk, parCode}),
    .syncOut(syncBus)
  );

  assign {modeS, leS, dataS, clkS, parS} = syncBus;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev <= 1'b0;
      lePrev  <= 1'b0;
    end else begin
      clkPrev <= clkS;
      lePrev  <= leS;
    end
  end

  always_comb begin
    strb.shiftEn   = modeS & clkS & ~clkPrev & ~leS;
    strb.serCommit = modeS & leS & ~lePrev;
    strb.parLoad   = ~modeS & leS;
    strb.dataBit   = dataS;
    strb.parValue  = parS;
  end

  // R2
  one_commit_per_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.serCommit |=> !strb.serCommit);
endmodule

// File: rtl/atten_datapath.sv
module atten_datapath
  import atten_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [ADDR_W-1:0] devAddr,
  output logic [CODE_W-1:0] attenCode,
  output logic              codeChanged
);
  localparam int FRAME_W = 2 * WORD_W;
  localparam logic [FRAME_W-1:0] RESET_FRAME =
    {{WORD_W{1'b0}}, {(WORD_W-CODE_W){1'b0}}, {CODE_W{1'b1}}};
  localparam logic [CODE_W-1:0] MAX_CODE = {CODE_W{1'b1}};

  logic [FRAME_W-1:0] shiftReg;
  logic [ADDR_W-1:0]  addrField;
  logic               addrHit;
  logic [CODE_W-1:0]  nextCode;

  assign addrField = shiftReg[WORD_W +: ADDR_W];
  assign addrHit   = (addrField == devAddr);

  // frame register: new bit enters at the top, so the first bit ends at bit 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              shiftReg <= RESET_FRAME;
    else if (strb.shiftEn)  shiftReg <= {strb.dataBit, shiftReg[FRAME_W-1:1]};
  end

  always_comb begin
    nextCode = attenCode;
    if (strb.serCommit && addrHit) nextCode = shiftReg[CODE_W-1:0];
    else if (strb.parLoad)         nextCode = strb.parValue;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      attenCode   <= MAX_CODE;
      codeChanged <= 1'b0;
    end else begin
      attenCode   <= nextCode;
      codeChanged <= (nextCode != attenCode);
    end
  end

  // R4
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shiftEn |=> $stable(shiftReg));

  // R2
  commit_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.serCommit && addrField == devAddr) |=> attenCode == $past(shiftReg[CODE_W-1:0]));

  // R3
  mismatch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.serCommit && addrField != devAddr) |=> $stable(attenCode));

  // R6
  par_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.parLoad |=> attenCode == $past(strb.parValue));

  // R9
  change_seen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (attenCode != $past(attenCode)) |-> codeChanged);

  // R9
  change_real_chk: assert property (@(posedge clk) disable iff (!rstN)
    codeChanged |-> (attenCode != $past(attenCode)));
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
  import atten_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              serLatch,
  input  logic              modeSerial,
  input  logic [CODE_W-1:0] parCode,
  input  logic [ADDR_W-1:0] devAddr,
  output logic [CODE_W-1:0] attenCode,
  output logic              codeChanged
);
  ctlStrobe_t strb;

  atten_ctrl_seq u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .serClk    (serClk),
    .serData   (serData),
    .serLatch  (serLatch),
    .modeSerial(modeSerial),
    .parCode   (parCode),
    .strb      (strb)
  );

  atten_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .devAddr    (devAddr),
    .attenCode  (attenCode),
    .codeChanged(codeChanged)
  );
endmodule

// File: tb/step_atten_ctrl_tb.sv
module step_atten_ctrl_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN = 1'b0;
  logic       serClk = 1'b0, serData = 1'b0, serLatch = 1'b1, modeSerial = 1'b1;
  logic [6:0] parCode = 7'h00;
  logic [2:0] devAddr = 3'd0;
  logic [6:0] attenCode;
  logic       codeChanged;

  int checks = 0, fails = 0, pulses = 0;
  bit running = 0, finished = 0;
  string curReq = "R1";

  step_atten_ctrl u_dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLatch(serLatch), .modeSerial(modeSerial), .parCode(parCode),
    .devAddr(devAddr), .attenCode(attenCode), .codeChanged(codeChanged)
  );

  // behavioural reference: inputs seen two and three edges back
  logic [10:0] d1, d2, d3;
  int frameM, actM, newAct;
  bit chgM;

  always @(posedge clk) begin
    if (!rstN) begin
      d1 = '0; d2 = '0; d3 = '0;
      frameM = 32'h007F; actM = 127; chgM = 0;
    end else begin
      newAct = actM;
      if (d2[10]) begin
        if (d2[7] && !d3[7] && !d2[9])
          frameM = (frameM >> 1) | (int'(d2[8]) << 15);
        else if (d2[9] && !d3[9] && (((frameM >> 8) & 7) == int'(devAddr)))
          newAct = frameM & 127;
      end else if (d2[9]) begin
        newAct = int'(d2[6:0]);
      end
      chgM = (newAct != actM);
      actM = newAct;
      d3 = d2; d2 = d1;
      d1 = {modeSerial, serLatch, serData, serClk, parCode};
    end
  end

  always @(negedge clk) begin
    if (running && rstN) begin
      checks++;
      if (attenCode !== actM[6:0] || codeChanged !== chgM) begin
        fails++;
        $display("FAIL %s per-cycle: code=%h chg=%b expected code=%h chg=%b",
                 curReq, attenCode, codeChanged, actM[6:0], chgM);
      end
      if (codeChanged) pulses++;
    end
  end

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(logic b);
    serData = b; waitCyc(3);
    serClk = 1'b1; waitCyc(3);
    serClk = 1'b0;
  endtask

  task automatic sendFrame(logic [7:0] att, logic [7:0] adr);
    logic [15:0] frame;
    frame = {adr, att};
    serLatch = 1'b0; waitCyc(3);
    for (int i = 0; i < 16; i++) sendBit(frame[i]);
    waitCyc(3);
    serLatch = 1'b1; waitCyc(6);
  endtask

  task automatic finish();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish();
    end
  end

  int p0;
  initial begin
    waitCyc(3);
    rstN = 1'b1;
    running = 1;
    // R1 reset state
    check("R1 code", attenCode, 7'h7F);
    check("R1 flag", codeChanged, 0);
    waitCyc(6);

    // R6 direct parallel with timing
    curReq = "R6";
    modeSerial = 1'b0; parCode = 7'h2A; waitCyc(6);
    check("R6 follow", attenCode, 7'h2A);
    parCode = 7'h15; waitCyc(2);
    check("R6 latency hold", attenCode, 7'h2A);
    waitCyc(1);
    check("R6 latency update", attenCode, 7'h15);
    check("R9 pulse on change", codeChanged, 1);
    waitCyc(1);
    check("R9 pulse one cycle", codeChanged, 0);

    // R7 latched parallel
    curReq = "R7";
    serLatch = 1'b0; waitCyc(4);
    parCode = 7'h33; waitCyc(6);
    check("R7 ignored while low", attenCode, 7'h15);
    serLatch = 1'b1; waitCyc(6);
    check("R7 captured on rise", attenCode, 7'h33);
    serLatch = 1'b0; waitCyc(4); parCode = 7'h01; waitCyc(6);
    check("R7 hold after capture", attenCode, 7'h33);

    // R10 reset frame committed with no serial clocks
    curReq = "R10";
    modeSerial = 1'b1; waitCyc(4);
    serLatch = 1'b1; waitCyc(6);
    check("R10 reset frame", attenCode, 7'h7F);

    // R2 serial commit
    curReq = "R2";
    sendFrame(8'h2C, 8'h00);
    check("R2 commit addr 0", attenCode, 7'h2C);
    devAddr = 3'd5;
    sendFrame(8'h11, 8'hFD);
    check("R3 upper address bits ignored", attenCode, 7'h11);
    curReq = "R3";
    sendFrame(8'h40, 8'h04);
    check("R3 mismatch keeps code", attenCode, 7'h11);

    // R5 bit 7 ignored
    curReq = "R5";
    sendFrame(8'h8A, 8'h05);
    check("R5 bit7 ignored", attenCode, 7'h0A);

    // R8 parallel pins ignored in serial mode
    curReq = "R8";
    parCode = 7'h5E; waitCyc(8);
    check("R8 par ignored in serial", attenCode, 7'h0A);

    // R4 latch high freezes shifting
    curReq = "R4";
    modeSerial = 1'b0; parCode = 7'h00; waitCyc(6);
    check("R4 setup zero", attenCode, 7'h00);
    modeSerial = 1'b1; waitCyc(4);
    for (int i = 0; i < 16; i++) sendBit(1'b1);
    serLatch = 1'b0; waitCyc(4);
    serLatch = 1'b1; waitCyc(6);
    check("R4 frame untouched", attenCode, 7'h0A);

    // R4 serial clock and latch rising in the same cycle
    modeSerial = 1'b0; waitCyc(6);
    check("R4 same-cycle setup", attenCode, 7'h00);
    modeSerial = 1'b1; waitCyc(4);
    serLatch = 1'b0; serClk = 1'b0; waitCyc(4);
    serData = 1'b1; serClk = 1'b1; serLatch = 1'b1; waitCyc(6);
    check("R4 same-cycle no shift", attenCode, 7'h0A);
    serClk = 1'b0; waitCyc(4);

    // R9 equal commit gives no pulse, a new value gives one
    curReq = "R9";
    p0 = pulses;
    sendFrame(8'h0A, 8'h05);
    check("R9 equal commit no pulse", pulses - p0, 0);
    p0 = pulses;
    sendFrame(8'h7E, 8'h05);
    check("R9 new value one pulse", pulses - p0, 1);
    check("R2 final commit", attenCode, 7'h7E);

    // R8 serial frame not committed in parallel mode
    curReq = "R8";
    modeSerial = 1'b0; parCode = 7'h66; waitCyc(4);
    sendFrame(8'h12, 8'h05);
    check("R8 parallel wins", attenCode, 7'h66);

    waitCyc(4);
    running = 0;
    finish();
  end
endmodule